// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Codec for 16-bit Words

This block guards a 16-bit data word with an extended Hamming code of 22 bits. It has two independent halves. The encoding half has no state. It turns a data word into a codeword that can be stored or sent over a link. The decoding half takes a codeword that may have been damaged and returns the recovered data word. It also returns one of three status indications: the word arrived intact, one bit was repaired, or the damage could not be repaired.

Five check bits form a Hamming syndrome over codeword positions 1 to 21. One extra bit holds even parity over the whole word. Taken together, the syndrome and the overall parity separate single upsets from double upsets. The decoder can have a register after the syndrome logic, a register on its outputs, both, or neither. Each of these is chosen by its own parameter, so the latency can be traded against logic depth per cycle. Both registers reset asynchronously.

Top module: `secded16_codec`

## Requirements
- R1: The encoder is combinational, with no registers. In the codeword, bit 0 makes the even parity of all 22 bits. Check bit j (j = 0..4) sits at position 2^j and gives even parity over every position 1..21 whose index has bit j set. The data bits fill positions 3, 5, 6, 7, 9–15 and 17–21 in ascending order, starting with data bit 0.
- R2: A codeword without damage returns the original data, and only the clean flag is high.
- R3: When any single bit at positions 1..21 is flipped, the decoder returns the original data exactly, and only the repaired flag is high.
- R4: When exactly two bits are flipped, only the fatal flag is high. The data output equals the received data bits without change, so it never differs from the original in more than those two positions.
- R5: When only the parity bit at position 0 is flipped, the decoder returns the original data, and only the repaired flag is high.
- R6: If the overall parity fails and the syndrome is 22 or higher, that syndrome names no position. Only the fatal flag is high, and the received data bits pass through unchanged.
- R7: In every cycle, exactly one of the three flags is high.
- R8: The decoder latency equals the number of register stages enabled, which is 2 cycles by default. A new codeword reaches the data output in that cycle and not one cycle earlier.
- R9: While reset is asserted, the decoder outputs all-zero data and only the clean flag is high, whatever codeword is at its input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the decoder registers |
| arst_n | input | 1 | Asynchronous reset, active low |
| enc_data_i | input | 16 | Data word to be encoded |
| enc_code_o | output | 22 | Codeword from the encoder (combinational) |
| dec_code_i | input | 22 | Codeword to be decoded, possibly damaged |
| dec_data_o | output | 16 | Recovered data word |
| dec_clean_o | output | 1 | Codeword arrived without error |
| dec_fixed_o | output | 1 | One bit was repaired |
| dec_fatal_o | output | 1 | Damage could not be repaired; data passed through |

## Verification
The properties on the data output compare it with the data bits of the codeword that was presented exactly one decoder latency earlier. They therefore assume that the codeword input is stable at every rising edge and fully defined once reset is released. The bench changes the input only on falling edges and drives a defined word during reset as well. The clean and fatal properties require the output to equal the raw received bits. The repaired property allows at most one changed bit. These properties hold for every input pattern, so the bench is free to inject three-bit patterns as well as single and double flips.

// File: rtl/secded16_pkg.sv
package secded16_pkg;

   typedef enum logic [1:0] {
      ST_CLEAN = 2'd0,
      ST_FIXED = 2'd1,
      ST_FATAL = 2'd2
   } dec_status_e;

   localparam int MASK_MAX = 64;

   // smallest syndrome width able to name every codeword position
   function automatic int syn_width(input int dw);
      for (int r = 1; r < 16; r++) begin
         if ((1 << r) >= dw + r + 1) return r;
      end
      return 16;
   endfunction

   function automatic int code_width(input int dw);
      return dw + syn_width(dw) + 1;
   endfunction

   function automatic bit is_pow2(input int p);
      return (p > 0) && ((p & (p - 1)) == 0);
   endfunction

   // codeword position of data bit k: k-th index >= 3 that is not a power of two
   function automatic int data_pos(input int k);
      int seen;
      seen = 0;
      for (int p = 3; p < MASK_MAX; p++) begin
         if (!is_pow2(p)) begin
            if (seen == k) return p;
            seen++;
         end
      end
      return 0;
   endfunction

   // positions 1..cw-1 whose index has bit j set
   function automatic logic [MASK_MAX-1:0] cover_mask(input int cw, input int j);
      logic [MASK_MAX-1:0] m;
      m = '0;
      for (int p = 1; p < MASK_MAX; p++) begin
         if (p < cw && ((p >> j) & 1) == 1) m[p] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
   import secded16_pkg::*;
#(
   parameter int DATA_W = 16
)(
   input  logic [DATA_W-1:0]              data_i,
   output logic [code_width(DATA_W)-1:0]  code_o
);

   localparam int SYN_W  = syn_width(DATA_W);
   localparam int CODE_W = code_width(DATA_W);

   if (CODE_W > MASK_MAX) begin : g_width_bad
      $error("secded_enc: codeword wider than mask limit");
   end
   if (DATA_W < 1) begin : g_data_bad
      $error("secded_enc: data width must be positive");
   end

   logic [CODE_W-1:1] placed;
   logic [CODE_W-1:1] body;
   logic [SYN_W-1:0]  chk;

   always_comb begin
      placed = '0;
      for (int k = 0; k < DATA_W; k++) begin
         placed[data_pos(k)] = data_i[k];
      end
   end

   for (genvar j = 0; j < SYN_W; j++) begin : g_chk
      localparam logic [MASK_MAX-1:0] COVER = cover_mask(CODE_W, j);
      assign chk[j] = ^(placed & COVER[CODE_W-1:1]);
   end

   always_comb begin
      body = placed;
      for (int j = 0; j < SYN_W; j++) begin
         body[1 << j] = chk[j];
      end
   end

   assign code_o = {body, ^body};

endmodule

// File: rtl/secded_syn.sv
module secded_syn
   import secded16_pkg::*;
#(
   parameter int DATA_W = 16
)(
   input  logic [code_width(DATA_W)-1:0] code_i,
   output logic [DATA_W-1:0]             data_o,
   output logic [syn_width(DATA_W)-1:0]  syn_o,
   output logic                          par_err_o
);

   localparam int SYN_W  = syn_width(DATA_W);
   localparam int CODE_W = code_width(DATA_W);

   if (CODE_W > MASK_MAX) begin : g_width_bad
      $error("secded_syn: codeword wider than mask limit");
   end

   for (genvar j = 0; j < SYN_W; j++) begin : g_syn
      localparam logic [MASK_MAX-1:0] COVER = cover_mask(CODE_W, j);
      assign syn_o[j] = ^(code_i & COVER[CODE_W-1:0]);
   end

   assign par_err_o = ^code_i;

   always_comb begin
      data_o = '0;
      for (int k = 0; k < DATA_W; k++) begin
         data_o[k] = code_i[data_pos(k)];
      end
   end

endmodule

// File: rtl/secded_fix.sv
module secded_fix
   import secded16_pkg::*;
#(
   parameter int DATA_W = 16
)(
   input  logic [DATA_W-1:0]            data_i,
   input  logic [syn_width(DATA_W)-1:0] syn_i,
   input  logic                         par_err_i,
   output logic [DATA_W-1:0]            data_o,
   output dec_status_e                  status_o
);

   localparam int SYN_W  = syn_width(DATA_W);
   localparam int CODE_W = code_width(DATA_W);

   logic syn_zero;
   logic syn_named;
   logic single;

   assign syn_zero  = (syn_i == '0);
   assign syn_named = (int'(syn_i) < CODE_W);
   assign single    = par_err_i && !syn_zero && syn_named;

   for (genvar k = 0; k < DATA_W; k++) begin : g_fix
      localparam int POS = data_pos(k);
      assign data_o[k] = data_i[k] ^ (single && (syn_i == SYN_W'(POS)));
   end

   always_comb begin
      if (!par_err_i && syn_zero)        status_o = ST_CLEAN;
      else if (par_err_i && syn_zero)    status_o = ST_FIXED;
      else if (single)                   status_o = ST_FIXED;
      else                               status_o = ST_FATAL;
   end

endmodule

// File: rtl/secded_stage.sv
module secded_stage #(
   parameter int W  = 8,
   parameter bit EN = 1'b1
)(
   input  logic         clk,
   input  logic         arst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (W < 1) begin : g_w_bad
      $error("secded_stage: width must be positive");
   end

   if (EN) begin : g_reg
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n) q_o <= '0;
         else         q_o <= d_i;
      end
   end else begin : g_wire
      assign q_o = d_i;
   end

endmodule

// File: rtl/secded16_codec.sv
module secded16_codec
   import secded16_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter bit MID_REG = 1'b1,
   parameter bit OUT_REG = 1'b1
)(
   input  logic                          clk,
   input  logic                          arst_n,
   input  logic [DATA_W-1:0]             enc_data_i,
   output logic [code_width(DATA_W)-1:0] enc_code_o,
   input  logic [code_width(DATA_W)-1:0] dec_code_i,
   output logic [DATA_W-1:0]             dec_data_o,
   output logic                          dec_clean_o,
   output logic                          dec_fixed_o,
   output logic                          dec_fatal_o
);

   localparam int SYN_W = syn_width(DATA_W);
   localparam int MID_W = DATA_W + SYN_W + 1;
   localparam int OUT_W = DATA_W + 2;

   if (code_width(DATA_W) > MASK_MAX) begin : g_width_bad
      $error("secded16_codec: data width too large");
   end

   // encoding half
   secded_enc #(.DATA_W(DATA_W)) u_enc (
      .data_i (enc_data_i),
      .code_o (enc_code_o)
   );

   // decoding half: syndrome
   logic [DATA_W-1:0] rx_data;
   logic [SYN_W-1:0]  rx_syn;
   logic              rx_par;

   secded_syn #(.DATA_W(DATA_W)) u_syn (
      .code_i    (dec_code_i),
      .data_o    (rx_data),
      .syn_o     (rx_syn),
      .par_err_o (rx_par)
   );

   // optional middle stage
   logic [MID_W-1:0] mid_q;
   logic [DATA_W-1:0] m_data;
   logic [SYN_W-1:0]  m_syn;
   logic              m_par;

   secded_stage #(.W(MID_W), .EN(MID_REG)) u_mid (
      .clk    (clk),
      .arst_n (arst_n),
      .d_i    ({rx_data, rx_syn, rx_par}),
      .q_o    (mid_q)
   );

   assign {m_data, m_syn, m_par} = mid_q;

   // correction
   logic [DATA_W-1:0] fx_data;
   dec_status_e       fx_status;

   secded_fix #(.DATA_W(DATA_W)) u_fix (
      .data_i    (m_data),
      .syn_i     (m_syn),
      .par_err_i (m_par),
      .data_o    (fx_data),
      .status_o  (fx_status)
   );

   // optional output stage; all-zero state reads as clean
   logic [OUT_W-1:0] out_q;
   logic [1:0]       o_status;

   secded_stage #(.W(OUT_W), .EN(OUT_REG)) u_out (
      .clk    (clk),
      .arst_n (arst_n),
      .d_i    ({fx_data, fx_status}),
      .q_o    (out_q)
   );

   assign {dec_data_o, o_status} = out_q;
   assign dec_clean_o = (o_status == ST_CLEAN);
   assign dec_fixed_o = (o_status == ST_FIXED);
   assign dec_fatal_o = !dec_clean_o && !dec_fixed_o;

endmodule

// File: rtl/secded16_codec_chk.sv
module secded16_codec_chk
   import secded16_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter bit MID_REG = 1'b1,
   parameter bit OUT_REG = 1'b1
)(
   input logic                          clk,
   input logic                          arst_n,
   input logic [DATA_W-1:0]             enc_data_i,
   input logic [code_width(DATA_W)-1:0] enc_code_o,
   input logic [code_width(DATA_W)-1:0] dec_code_i,
   input logic [DATA_W-1:0]             dec_data_o,
   input logic                          dec_clean_o,
   input logic                          dec_fixed_o,
   input logic                          dec_fatal_o
);

   localparam int LAT = int'(MID_REG) + int'(OUT_REG);

   logic [DATA_W-1:0] enc_placed;
   logic [DATA_W-1:0] rx_now;
   logic [DATA_W-1:0] rx_hist [0:LAT];
   logic [1:0]        seen;
   logic              ready;

   always_comb begin
      enc_placed = '0;
      rx_now     = '0;
      for (int k = 0; k < DATA_W; k++) begin
         enc_placed[k] = enc_code_o[data_pos(k)];
         rx_now[k]     = dec_code_i[data_pos(k)];
      end
   end

   assign rx_hist[0] = rx_now;

   for (genvar i = 1; i <= LAT; i++) begin : g_hist
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n) rx_hist[i] <= '0;
         else         rx_hist[i] <= rx_hist[i-1];
      end
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)                seen <= 2'd0;
      else if (seen != 2'(LAT))   seen <= seen + 2'd1;
   end

   assign ready = (seen == 2'(LAT));

   AST_ENC_SYSTEMATIC: assert property (@(posedge clk) disable iff (!arst_n)
      enc_placed == enc_data_i);                                             // R1

   AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!arst_n)
      $countones({dec_clean_o, dec_fixed_o, dec_fatal_o}) == 1);             // R7

   AST_CLEAN_INTACT: assert property (@(posedge clk) disable iff (!arst_n)
      (ready && dec_clean_o) |-> (dec_data_o == rx_hist[LAT]));              // R2

   AST_FATAL_RAW: assert property (@(posedge clk) disable iff (!arst_n)
      (ready && dec_fatal_o) |-> (dec_data_o == rx_hist[LAT]));              // R4

   AST_FIX_ONE_BIT: assert property (@(posedge clk) disable iff (!arst_n)
      (ready && dec_fixed_o) |-> ($countones(dec_data_o ^ rx_hist[LAT]) <= 1)); // R3

   always @(negedge clk) begin
      if (!arst_n && LAT > 0) begin
         AST_RST_CLEAN: assert (dec_clean_o && dec_data_o == '0);            // R9
      end
   end

endmodule

bind secded16_codec secded16_codec_chk #(
   .DATA_W  (DATA_W),
   .MID_REG (MID_REG),
   .OUT_REG (OUT_REG)
) u_chk (.*);

// File: tb/sim_secded16_codec.sv
module sim_secded16_codec;

   localparam int DW  = 16;
   localparam int CW  = 22;
   localparam int LAT = 2;

   logic          clk = 1'b0;
   logic          arst_n;
   logic [DW-1:0] enc_data;
   logic [CW-1:0] enc_code;
   logic [CW-1:0] dec_code;
   logic [DW-1:0] dec_data;
   logic          f_clean, f_fixed, f_fatal;

   int vectors = 0;
   int miscompares = 0;

   always #4 clk = ~clk;

   secded16_codec u0 (
      .clk         (clk),
      .arst_n      (arst_n),
      .enc_data_i  (enc_data),
      .enc_code_o  (enc_code),
      .dec_code_i  (dec_code),
      .dec_data_o  (dec_data),
      .dec_clean_o (f_clean),
      .dec_fixed_o (f_fixed),
      .dec_fatal_o (f_fatal)
   );

   function automatic bit b_pow2(input int p);
      return (p > 0) && ((p & (p - 1)) == 0);
   endfunction

   // reference encoder built from the R1 layout
   function automatic logic [CW-1:0] b_encode(input logic [DW-1:0] d);
      logic [CW-1:0] c;
      int k;
      c = '0;
      k = 0;
      for (int p = 3; p < CW; p++) begin
         if (!b_pow2(p)) begin
            c[p] = d[k];
            k++;
         end
      end
      for (int j = 0; j < 5; j++) begin
         logic x;
         x = 1'b0;
         for (int p = 3; p < CW; p++) begin
            if (!b_pow2(p) && ((p >> j) & 1) == 1) x = x ^ c[p];
         end
         c[1 << j] = x;
      end
      c[0] = ^c[CW-1:1];
      return c;
   endfunction

   // data bits touched by a codeword flip mask
   function automatic logic [DW-1:0] b_data_of(input logic [CW-1:0] m);
      logic [DW-1:0] d;
      int k;
      d = '0;
      k = 0;
      for (int p = 3; p < CW; p++) begin
         if (!b_pow2(p)) begin
            d[k] = m[p];
            k++;
         end
      end
      return d;
   endfunction

   task automatic check_out(input string req, input logic [DW-1:0] exp_d,
                            input logic [2:0] exp_f);
      vectors++;
      if (dec_data !== exp_d || {f_clean, f_fixed, f_fatal} !== exp_f) begin
         miscompares++;
         $display("FAIL %s: data %h flags %b, expected data %h flags %b",
                  req, dec_data, {f_clean, f_fixed, f_fatal}, exp_d, exp_f);
      end
   endtask

   // drive one word through the encoder, damage it, decode it
   task automatic apply(input logic [DW-1:0] d, input logic [CW-1:0] mask);
      @(negedge clk);
      enc_data = d;
      #1;
      dec_code = enc_code ^ mask;
      repeat (LAT) @(negedge clk);
   endtask

   task automatic t_reset;
      arst_n   = 1'b0;
      enc_data = 16'hFFFF;
      dec_code = 22'h3A5A5A;
      repeat (3) @(negedge clk);
      check_out("R9 reset", 16'h0000, 3'b100);
      dec_code = 22'h155555;
      @(negedge clk);
      check_out("R9 reset input ignored", 16'h0000, 3'b100);
      arst_n = 1'b1;
   endtask

   task automatic t_encoder;
      logic [DW-1:0] pats [5] = '{16'h0000, 16'hFFFF, 16'h8001, 16'h1234, 16'hC3A5};
      foreach (pats[i]) begin
         @(negedge clk);
         enc_data = pats[i];
         #1;
         vectors++;
         if (enc_code !== b_encode(pats[i])) begin
            miscompares++;
            $display("FAIL R1 encode %h: got %h expected %h",
                     pats[i], enc_code, b_encode(pats[i]));
         end
      end
   endtask

   task automatic t_clean;
      logic [DW-1:0] pats [5] = '{16'h0000, 16'hFFFF, 16'hA5A5, 16'h1234, 16'h8001};
      foreach (pats[i]) begin
         apply(pats[i], '0);
         check_out("R2 clean", pats[i], 3'b100);
      end
   endtask

   task automatic t_single;
      logic [DW-1:0] pats [2] = '{16'h5A3C, 16'h0F0F};
      foreach (pats[i]) begin
         for (int p = 0; p < CW; p++) begin
            apply(pats[i], CW'(1) << p);
            if (p == 0) check_out("R5 parity bit flip", pats[i], 3'b010);
            else        check_out("R3 single flip", pats[i], 3'b010);
         end
      end
   endtask

   task automatic t_double;
      int pa [6] = '{0, 3, 1, 9, 20, 2};
      int pb [6] = '{5, 17, 2, 21, 21, 6};
      logic [DW-1:0] d;
      logic [CW-1:0] m;
      foreach (pa[i]) begin
         d = 16'h6E91 ^ DW'(i * 16'h1111);
         m = (CW'(1) << pa[i]) | (CW'(1) << pb[i]);
         apply(d, m);
         check_out("R4 double flip", d ^ b_data_of(m), 3'b001);
      end
   endtask

   task automatic t_bad_syndrome;
      logic [CW-1:0] m;
      // syndrome 2^4^16 = 22
      m = (CW'(1) << 2) | (CW'(1) << 4) | (CW'(1) << 16);
      apply(16'h3C5A, m);
      check_out("R6 syndrome 22", 16'h3C5A, 3'b001);
      // syndrome 2^8^16 = 26
      m = (CW'(1) << 2) | (CW'(1) << 8) | (CW'(1) << 16);
      apply(16'hBEEF, m);
      check_out("R6 syndrome 26", 16'hBEEF, 3'b001);
      // syndrome 1^12^18 = 31, data bits pass through still flipped
      m = (CW'(1) << 1) | (CW'(1) << 12) | (CW'(1) << 18);
      apply(16'h0123, m);
      check_out("R6 syndrome 31", 16'h0123 ^ b_data_of(m), 3'b001);
   endtask

   task automatic t_latency;
      apply(16'h1111, '0);
      @(negedge clk);
      enc_data = 16'h2222;
      #1;
      dec_code = enc_code ^ (CW'(1) << 7);
      @(negedge clk);
      check_out("R8 one cycle after change", 16'h1111, 3'b100);
      @(negedge clk);
      check_out("R8 two cycles after change", 16'h2222, 3'b010);
   endtask

   initial begin
      t_reset();
      t_encoder();
      t_clean();
      t_single();
      t_double();
      t_bad_syndrome();
      t_latency();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      miscompares++;
      $display("FAIL R8 watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule